// File: doc/BRIEF.md
# Dual-Lane 16-bit Vector Shifter

This block is the shift stage of a DSP datapath. It splits a 32-bit operand into two signed 16-bit lanes and moves both lanes by one common signed count. A positive count moves bits toward the most significant end and a negative count moves them toward the least significant end. No bit ever crosses from one lane into the other. Two mode bits pick an arithmetic or a logical shift and turn optional per-lane saturation on or off.

The count is clamped to the range -16..+15. Each lane is shifted on its own, and the two lanes are then combined into one packed result and a set of status flags. The result and the flags are captured in registers on the clock edge where `valid_in` is high. They hold their value until the next valid strobe. The zero and negative flags report a condition in either lane. The carry and the two overflow flags stay clear for this operation class, even when a lane saturates.

Top module: `dual_lane_shifter`

## Requirements
- R1: While `rst_n` is low, `result` and all five flags read 0.
- R2: With a count from 1 to 15 and saturation off (op[1]=0), or in logical mode, each lane is shifted left on its own. Bits that leave bit 15 of a lane are discarded, and the vacated low bits are filled with 0.
- R3: In arithmetic mode with saturation on (op = 2'b10), a left shift whose true signed result does not fit in 16 bits clamps that lane alone. A lane whose input is non-negative clamps to 0x7FFF, and a lane whose input is negative clamps to 0x8000. A lane that does not overflow gets the plain shifted value.
- R4: In arithmetic mode (op[0]=0), a negative count shifts each lane right and fills the top with copies of the lane's bit 15. The saturation bit has no effect on a right shift.
- R5: In logical mode (op[0]=1), a right shift fills each lane with zeros. The saturation bit op[1] is ignored in logical mode.
- R6: The count is a 6-bit two's-complement value. A count of 0 passes both lanes through unchanged. A count above +15 acts as +15, and a count below -16 acts as -16.
- R7: `flag_zero` is 1 when at least one lane of the result equals 0x0000.
- R8: `flag_neg` is 1 when bit 15 or bit 31 of the result is set.
- R9: `flag_carry`, `flag_ovf0` and `flag_ovf1` read 0 after every operation, including operations that saturate.
- R10: The result and the flags are loaded on the rising edge where `valid_in` is 1. They hold their value on every edge where `valid_in` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_in | input | 1 | Capture strobe for a new operation |
| operand | input | 32 | Two packed signed lanes: bits 31:16 are the high lane, bits 15:0 the low lane |
| shift_amt | input | 6 | Signed shift count; positive shifts left, negative shifts right |
| op | input | 2 | op[0]=1 selects logical mode; op[1]=1 enables saturation |
| result | output | 32 | Registered packed lane results |
| flag_zero | output | 1 | Either lane of the result is zero |
| flag_neg | output | 1 | Either lane of the result is negative |
| flag_carry | output | 1 | Carry status, always cleared by this operation |
| flag_ovf0 | output | 1 | First overflow status, always cleared |
| flag_ovf1 | output | 1 | Second overflow status, always cleared |

## Verification
The bench builds the block with its default parameters: 16-bit lanes, two lanes and a 6-bit count. With a 6-bit count, every clamp case is reachable: the counts +31 and -32 fold to +15 and -16, and -16 pushes a whole lane out. The vector table covers plain and saturating left shifts where the two lanes overflow differently. It covers arithmetic and logical right shifts of sign-heavy lanes, and results where one lane is 0x0000 and the other is 0x8000, which raise the zero and negative flags together.

// File: rtl/shf_pkg.sv
package shf_pkg;
  // Mode word: bit 1 enables saturation, bit 0 selects logical mode
  typedef struct packed {
    logic sat;
    logic logical;
  } shf_mode_t;
endpackage

// File: rtl/shf_count_clamp.sv
module shf_count_clamp #(
  parameter int LANE_W = 16,
  parameter int CNT_W  = 6,
  localparam int MAG_W = $clog2(LANE_W + 1)
) (
  input  logic [CNT_W-1:0] count,
  output logic             go_left,
  output logic [MAG_W-1:0] mag
);
  localparam int MAX_LEFT  = LANE_W - 1;
  localparam int MAX_RIGHT = LANE_W;

  int cnt_i;

  always_comb begin
    cnt_i   = int'($signed(count));
    go_left = (cnt_i >= 0);
    if (cnt_i > MAX_LEFT) begin
      mag = MAG_W'(MAX_LEFT);
    end else if (cnt_i < -MAX_RIGHT) begin
      mag = MAG_W'(MAX_RIGHT);
    end else if (cnt_i >= 0) begin
      mag = MAG_W'(cnt_i);
    end else begin
      mag = MAG_W'(-cnt_i);
    end
  end
endmodule

// File: rtl/shf_lane.sv
module shf_lane #(
  parameter int LANE_W = 16,
  localparam int MAG_W = $clog2(LANE_W + 1),
  localparam int EXT_W = 2 * LANE_W
) (
  input  logic [LANE_W-1:0] din,
  input  logic              go_left,
  input  logic [MAG_W-1:0]  mag,
  input  shf_pkg::shf_mode_t mode,
  output logic [LANE_W-1:0] dout,
  output logic              is_zero,
  output logic              is_neg
);
  localparam logic [LANE_W-1:0] POS_LIMIT = {1'b0, {(LANE_W-1){1'b1}}};
  localparam logic [LANE_W-1:0] NEG_LIMIT = {1'b1, {(LANE_W-1){1'b0}}};

  logic              sign_fill;
  logic [EXT_W-1:0]  ext;
  logic [EXT_W-1:0]  left_val;
  logic [EXT_W-1:0]  right_val;
  logic [LANE_W:0]   top_bits;
  logic              overflow;
  logic              clamp;

  always_comb begin
    // Logical mode zero-extends, so one arithmetic shifter serves both modes
    sign_fill = din[LANE_W-1] & ~mode.logical;
    ext       = {{LANE_W{sign_fill}}, din};
    left_val  = ext << mag;
    right_val = EXT_W'($signed(ext) >>> mag);
    top_bits  = left_val[EXT_W-1:LANE_W-1];
    overflow  = ~((&top_bits) | ~(|top_bits));
    clamp     = go_left & mode.sat & ~mode.logical & overflow;
    if (clamp) begin
      dout = din[LANE_W-1] ? NEG_LIMIT : POS_LIMIT;
    end else if (go_left) begin
      dout = left_val[LANE_W-1:0];
    end else begin
      dout = right_val[LANE_W-1:0];
    end
    is_zero = ~(|dout);
    is_neg  = dout[LANE_W-1];
  end
endmodule

// File: rtl/dual_lane_shifter.sv
module dual_lane_shifter #(
  parameter int LANE_W = 16,
  parameter int LANES  = 2,
  parameter int CNT_W  = 6,
  localparam int DATA_W = LANE_W * LANES,
  localparam int MAG_W  = $clog2(LANE_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid_in,
  input  logic [DATA_W-1:0] operand,
  input  logic [CNT_W-1:0]  shift_amt,
  input  logic [1:0]        op,
  output logic [DATA_W-1:0] result,
  output logic              flag_zero,
  output logic              flag_neg,
  output logic              flag_carry,
  output logic              flag_ovf0,
  output logic              flag_ovf1
);
  shf_pkg::shf_mode_t mode;
  logic               go_left;
  logic [MAG_W-1:0]   mag;
  logic [DATA_W-1:0]  lane_out;
  logic [LANES-1:0]   lane_zero;
  logic [LANES-1:0]   lane_neg;

  logic [DATA_W-1:0]  result_d;
  logic               zero_d, neg_d, carry_d, ovf0_d, ovf1_d;

  assign mode = shf_pkg::shf_mode_t'(op);

  shf_count_clamp #(.LANE_W(LANE_W), .CNT_W(CNT_W)) clamp_i (
    .count   (shift_amt),
    .go_left (go_left),
    .mag     (mag)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    shf_lane #(.LANE_W(LANE_W)) lane_i (
      .din     (operand[g*LANE_W +: LANE_W]),
      .go_left (go_left),
      .mag     (mag),
      .mode    (mode),
      .dout    (lane_out[g*LANE_W +: LANE_W]),
      .is_zero (lane_zero[g]),
      .is_neg  (lane_neg[g])
    );
  end

  // Next-state logic with explicit enable
  always_comb begin
    result_d = result;
    zero_d   = flag_zero;
    neg_d    = flag_neg;
    carry_d  = flag_carry;
    ovf0_d   = flag_ovf0;
    ovf1_d   = flag_ovf1;
    if (valid_in) begin
      result_d = lane_out;
      zero_d   = |lane_zero;
      neg_d    = |lane_neg;
      carry_d  = 1'b0;
      ovf0_d   = 1'b0;
      ovf1_d   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result     <= '0;
      flag_zero  <= 1'b0;
      flag_neg   <= 1'b0;
      flag_carry <= 1'b0;
      flag_ovf0  <= 1'b0;
      flag_ovf1  <= 1'b0;
    end else begin
      result     <= result_d;
      flag_zero  <= zero_d;
      flag_neg   <= neg_d;
      flag_carry <= carry_d;
      flag_ovf0  <= ovf0_d;
      flag_ovf1  <= ovf1_d;
    end
  end
endmodule

// File: rtl/dual_lane_shifter_checker.sv
module dual_lane_shifter_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        valid_in,
  input logic [31:0] operand,
  input logic [5:0]  shift_amt,
  input logic [1:0]  op,
  input logic [31:0] result,
  input logic        flag_zero,
  input logic        flag_neg
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_clear_R1: assert (result == 32'h0 && !flag_zero && !flag_neg);
    end
  end

  assert_arith_sign_fill_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_in && !op[0] && shift_amt[5]) |=>
      (result[15] == $past(operand[15]) && result[31] == $past(operand[31])));

  assert_logic_zero_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_in && op[0] && shift_amt[5]) |=> (!result[15] && !result[31]));

  assert_zero_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flag_zero == (result[15:0] == 16'h0 || result[31:16] == 16'h0) || $stable(result) && $stable(flag_zero));

  assert_neg_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(valid_in) |-> (flag_neg == (result[15] | result[31])));

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_in |=> ($stable(result) && $stable(flag_zero) && $stable(flag_neg)));
endmodule

bind dual_lane_shifter dual_lane_shifter_checker chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .valid_in  (valid_in),
  .operand   (operand),
  .shift_amt (shift_amt),
  .op        (op),
  .result    (result),
  .flag_zero (flag_zero),
  .flag_neg  (flag_neg)
);

// File: tb/dual_lane_shifter_tb_top.sv
module dual_lane_shifter_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 19;

  // {operand, count, op, expected result, expected zero, expected neg}
  localparam logic [73:0] VEC [NVEC] = '{
    {32'h0100_8001, 6'd15,   2'b00, 32'h0000_8000, 1'b1, 1'b1}, // R2 R7 R8
    {32'h0100_8001, 6'd15,   2'b10, 32'h7FFF_8000, 1'b0, 1'b1}, // R3
    {32'h0100_8001, 6'd1,    2'b00, 32'h0200_0002, 1'b0, 1'b0}, // R2
    {32'h0100_8001, 6'd1,    2'b10, 32'h0200_8000, 1'b0, 1'b1}, // R3
    {32'h0000_FFF0, 6'd15,   2'b10, 32'h0000_8000, 1'b1, 1'b1}, // R3
    {32'h0100_8000, 6'h31,   2'b00, 32'h0000_FFFF, 1'b1, 1'b1}, // R4
    {32'h0100_8000, 6'h31,   2'b10, 32'h0000_FFFF, 1'b1, 1'b1}, // R4 sat no effect
    {32'h0100_8000, 6'h31,   2'b01, 32'h0000_0001, 1'b1, 1'b0}, // R5
    {32'h0100_8000, 6'h31,   2'b11, 32'h0000_0001, 1'b1, 1'b0}, // R5 sat ignored
    {32'h0100_8001, 6'd1,    2'b11, 32'h0200_0002, 1'b0, 1'b0}, // R5 logical left plain
    {32'h8001_1234, 6'd0,    2'b10, 32'h8001_1234, 1'b0, 1'b1}, // R6 pass through
    {32'h0003_0001, 6'h1F,   2'b00, 32'h8000_8000, 1'b0, 1'b1}, // R6 +31 -> +15
    {32'h8000_7FFF, 6'h20,   2'b00, 32'hFFFF_0000, 1'b1, 1'b1}, // R6 -32 -> -16
    {32'h8000_7FFF, 6'h20,   2'b01, 32'h0000_0000, 1'b1, 1'b0}, // R6 logical -16
    {32'h7FFF_8000, 6'h30,   2'b00, 32'h0000_FFFF, 1'b1, 1'b1}, // R6 -16 exact
    {32'h0F00_F000, 6'h3C,   2'b00, 32'h00F0_FF00, 1'b0, 1'b1}, // R4
    {32'h0003_FFFD, 6'd2,    2'b10, 32'h000C_FFF4, 1'b0, 1'b1}, // R3 no overflow
    {32'h0000_FFFF, 6'd4,    2'b00, 32'h0000_FFF0, 1'b1, 1'b1}, // R2 lane isolation
    {32'hFFFF_0000, 6'h3C,   2'b01, 32'h0FFF_0000, 1'b1, 1'b0}  // R5 lane isolation
  };

  logic        clk;
  logic        rst_n;
  logic        valid_in;
  logic [31:0] operand;
  logic [5:0]  shift_amt;
  logic [1:0]  op;
  logic [31:0] result;
  logic        flag_zero, flag_neg, flag_carry, flag_ovf0, flag_ovf1;

  int checks;
  int fails;
  bit done;

  dual_lane_shifter dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .valid_in   (valid_in),
    .operand    (operand),
    .shift_amt  (shift_amt),
    .op         (op),
    .result     (result),
    .flag_zero  (flag_zero),
    .flag_neg   (flag_neg),
    .flag_carry (flag_carry),
    .flag_ovf0  (flag_ovf0),
    .flag_ovf1  (flag_ovf1)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [31:0] a, input logic [5:0] c, input logic [1:0] m);
    @(negedge clk);
    operand   = a;
    shift_amt = c;
    op        = m;
    valid_in  = 1'b1;
    @(negedge clk);
    valid_in  = 1'b0;
  endtask

  initial begin
    checks = 0; fails = 0; done = 1'b0;
    rst_n = 1'b0; valid_in = 1'b0; operand = '0; shift_amt = '0; op = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 reset result", result, 32'h0);
    check("R1 reset flags", {27'h0, flag_zero, flag_neg, flag_carry, flag_ovf0, flag_ovf1}, 32'h0);
    rst_n = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      apply(VEC[i][73:42], VEC[i][41:36], VEC[i][35:34]);
      check($sformatf("R2-6 vec%0d result", i), result, VEC[i][33:2]);
      check($sformatf("R7 vec%0d zero", i), {31'h0, flag_zero}, {31'h0, VEC[i][1]});
      check($sformatf("R8 vec%0d neg", i), {31'h0, flag_neg}, {31'h0, VEC[i][0]});
      check($sformatf("R9 vec%0d carry/ovf", i), {29'h0, flag_carry, flag_ovf0, flag_ovf1}, 32'h0);
    end

    // R10: no strobe, inputs change, outputs hold
    apply(32'h0100_8001, 6'd15, 2'b10);
    @(negedge clk);
    operand = 32'h1234_5678; shift_amt = 6'd3; op = 2'b00;
    repeat (3) @(negedge clk);
    check("R10 hold result", result, 32'h7FFF_8000);
    check("R10 hold flags", {30'h0, flag_zero, flag_neg}, 32'h1);

    // R1: reset mid-run clears
    rst_n = 1'b0;
    #1;
    check("R1 mid-run reset", result, 32'h0);
    check("R1 mid-run flags", {30'h0, flag_zero, flag_neg}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    apply(32'h0000_0001, 6'd0, 2'b01);
    check("R6 after reset zero count", result, 32'h0000_0001);
    check("R7 after reset zero flag", {31'h0, flag_zero}, 32'h1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule